// File: doc/BRIEF.md
# Thermal and Overclock Governor

This block decides the operating point of a processor core from two inputs: a temperature reading and a count of timing errors seen since the last frequency decision. It drives a voltage level index, a frequency level index, a panic flag and an overclock-enable flag. Physical actuators sit outside the block.

In the combined mode, thermal safety comes first. A slow thermal timer lowers the voltage index while the core is hot. It raises the index when the core is cool. If the core is still hot at the lowest voltage, the block raises panic, pulls the frequency to its floor and disables overclocking. A faster tuning timer steps the frequency up or down from the error count, but only while overclocking is enabled. The tuning timer also pulses a clear toward the external error counter.

A parameter can instead select a simpler throttling mode. It has one shared interval and a fixed voltage. In this mode, heat and excess errors both push the frequency down.

Top module: `thermal_oc_governor`

## Requirements
- R1: Reset gives vlevel = VLEVELS-1, flevel = 0, panic = 0, oc_en = 1 and err_clr = 0.
- R2: In combined mode a thermal evaluation occurs on every (V_INTERVAL+1)-th rising edge after reset release, the first one on edge V_INTERVAL+1; between evaluations vlevel, panic and oc_en do not change.
- R3: At a thermal evaluation the core counts as hot when temp >= temp_limit (inclusive). If hot and vlevel > 0, vlevel decreases by one. If not hot, vlevel increases by one, saturating at VLEVELS-1, and panic is cleared.
- R4: At a thermal evaluation that is hot with vlevel = 0, panic is set, flevel is forced to 0 and oc_en is cleared, all on that same edge.
- R5: oc_en returns to 1 only at a thermal evaluation with temp < temp_limit. While oc_en = 0, tuning evaluations leave flevel unchanged.
- R6: At a tuning evaluation, err_count > err_limit (strict) lowers flevel by one, stopping at 0. Otherwise flevel rises by one, saturating at FLEVELS-1. err_clr is 1 during exactly the cycle in which a tuning evaluation is performed.
- R7: When a tuning evaluation and a thermal evaluation fall due in the same cycle, only the thermal one is performed, and the tuning evaluation is performed on the following cycle.
- R8: In combined mode a tuning evaluation falls due F_INTERVAL+1 edges after the previous one was performed (or after reset).
- R9: In throttling mode (VARIANT = GOV_THROTTLE) one interval of F_INTERVAL+1 edges drives everything. At each evaluation flevel steps down when temp > temp_limit (strict) or err_count > err_limit, and steps up otherwise. At the same evaluation, panic is set to (temp > temp_limit and flevel = 0). vlevel stays at VLEVELS-1, oc_en stays 1, and err_clr pulses at each evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp | input | TEMP_W | Hottest sensor reading |
| temp_limit | input | TEMP_W | Thermal threshold |
| err_count | input | ERR_W | Timing errors since last clear |
| err_limit | input | ERR_W | Allowed error count per tuning interval |
| vlevel | output | $clog2(VLEVELS) | Voltage level index, 0 is lowest |
| flevel | output | $clog2(FLEVELS) | Frequency level index, 0 is lowest |
| panic | output | 1 | Hot at minimum voltage (or minimum frequency in throttling mode) |
| oc_en | output | 1 | Overclocking permitted |
| err_clr | output | 1 | One-cycle pulse to clear the external error counter |

## Verification
The first patterns are a cool, error-free run, which shows saturation at the top frequency, and an error count equal to the limit, which must still count as a pass. An error count one above the limit then drives the frequency to the floor. A temperature exactly at the threshold separates the inclusive thermal test of the combined mode from the strict test of the throttling mode, which runs in a second instance on the same inputs. A sustained hot phase walks the voltage down to zero and into panic, and the cool phase after it shows that overclocking comes back only at a thermal evaluation. A long sweep of interleaved temperature and error patterns is compared every cycle against an arithmetic model of both timers, and in this configuration thermal and tuning evaluations collide regularly, which exposes the deferral rule.

// File: rtl/gov_pkg.sv
package gov_pkg;

   typedef enum int {
      GOV_COMBINED = 0,
      GOV_THROTTLE = 1
   } gov_variant_e;

endpackage

// File: rtl/gov_interval.sv
module gov_interval #(
   parameter int LIMIT = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic due
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   assign due = (cnt == LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!due) begin
         cnt <= cnt + 1'b1;
      end else if (!hold) begin
         cnt <= '0;
      end
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (due && hold) |=> due);

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !hold) |=> (cnt == '0));

endmodule

// File: rtl/gov_thermal.sv
module gov_thermal #(
   parameter int VLEVELS = 4,
   parameter int VW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eval,
   input  logic          hot,
   output logic [VW-1:0] vlevel,
   output logic          panic,
   output logic          oc_en,
   output logic          floor_req
);
   localparam logic [VW-1:0] VMAX = VW'(VLEVELS - 1);

   assign floor_req = eval && hot && (vlevel == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vlevel <= VMAX;
         panic  <= 1'b0;
         oc_en  <= 1'b1;
      end else if (eval) begin
         if (hot) begin
            if (vlevel != '0) begin
               vlevel <= vlevel - 1'b1;
            end else begin
               panic <= 1'b1;
               oc_en <= 1'b0;
            end
         end else begin
            if (vlevel != VMAX) vlevel <= vlevel + 1'b1;
            panic <= 1'b0;
            oc_en <= 1'b1;
         end
      end
   end

   p_vdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && hot && vlevel != '0) |=> (vlevel == $past(vlevel) - 1'b1));

   p_vup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !hot && vlevel != VMAX) |=> (vlevel == $past(vlevel) + 1'b1));

   p_panic_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && hot && vlevel == '0) |=> (panic && !oc_en));

   p_oc_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !hot) |=> (oc_en && !panic));

   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> ($stable(vlevel) && $stable(oc_en) && $stable(panic)));

endmodule

// File: rtl/gov_ftune.sv
module gov_ftune #(
   parameter int FLEVELS = 8,
   parameter int FW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tune,
   input  logic          enable,
   input  logic          over,
   input  logic          force_floor,
   output logic [FW-1:0] flevel
);
   localparam logic [FW-1:0] FMAX = FW'(FLEVELS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flevel <= '0;
      end else if (force_floor) begin
         flevel <= '0;
      end else if (tune && enable) begin
         if (over) begin
            if (flevel != '0) flevel <= flevel - 1'b1;
         end else if (flevel != FMAX) begin
            flevel <= flevel + 1'b1;
         end
      end
   end

   p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
      force_floor |=> (flevel == '0));

   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tune && !force_floor) |=> $stable(flevel));

   p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tune && !enable && !force_floor) |=> $stable(flevel));

   p_fdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tune && enable && over && !force_floor && flevel != '0)
      |=> (flevel == $past(flevel) - 1'b1));

endmodule

// File: rtl/thermal_oc_governor.sv
module thermal_oc_governor
   import gov_pkg::*;
#(
   parameter gov_variant_e VARIANT    = GOV_COMBINED,
   parameter int           VLEVELS    = 4,
   parameter int           FLEVELS    = 8,
   parameter int           TEMP_W     = 8,
   parameter int           ERR_W      = 8,
   parameter int           V_INTERVAL = 1000,
   parameter int           F_INTERVAL = 100,
   localparam int          VW         = $clog2(VLEVELS),
   localparam int          FW         = $clog2(FLEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] temp_limit,
   input  logic [ERR_W-1:0]  err_count,
   input  logic [ERR_W-1:0]  err_limit,
   output logic [VW-1:0]     vlevel,
   output logic [FW-1:0]     flevel,
   output logic              panic,
   output logic              oc_en,
   output logic              err_clr
);
   generate
      if (VLEVELS < 2) begin : g_bad_v
         $error("thermal_oc_governor: VLEVELS must be at least 2");
      end
      if (FLEVELS < 2) begin : g_bad_f
         $error("thermal_oc_governor: FLEVELS must be at least 2");
      end
      if (V_INTERVAL < 1 || F_INTERVAL < 1) begin : g_bad_i
         $error("thermal_oc_governor: intervals must be at least 1");
      end
   endgenerate

   logic err_over;
   assign err_over = (err_count > err_limit);

   generate
      if (VARIANT == GOV_COMBINED) begin : g_comb
         logic t_due;
         logic f_due;
         logic hot;
         logic tune;
         logic floor_req;

         assign hot  = (temp >= temp_limit);
         assign tune = f_due && !t_due;

         gov_interval #(.LIMIT(V_INTERVAL)) u_ttimer (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (1'b0),
            .due   (t_due)
         );

         gov_interval #(.LIMIT(F_INTERVAL)) u_ftimer (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (t_due),
            .due   (f_due)
         );

         gov_thermal #(.VLEVELS(VLEVELS), .VW(VW)) u_thermal (
            .clk       (clk),
            .rst_n     (rst_n),
            .eval      (t_due),
            .hot       (hot),
            .vlevel    (vlevel),
            .panic     (panic),
            .oc_en     (oc_en),
            .floor_req (floor_req)
         );

         gov_ftune #(.FLEVELS(FLEVELS), .FW(FW)) u_ftune (
            .clk         (clk),
            .rst_n       (rst_n),
            .tune        (tune),
            .enable      (oc_en),
            .over        (err_over),
            .force_floor (floor_req),
            .flevel      (flevel)
         );

         assign err_clr = tune;

         p_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (t_due && f_due) |=> err_clr);

         p_floor_panic_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (t_due && hot && vlevel == '0) |=> (flevel == '0 && panic));

      end else begin : g_thr
         logic due;
         logic hot_s;
         logic panic_q;

         assign hot_s = (temp > temp_limit);

         gov_interval #(.LIMIT(F_INTERVAL)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (1'b0),
            .due   (due)
         );

         gov_ftune #(.FLEVELS(FLEVELS), .FW(FW)) u_ftune (
            .clk         (clk),
            .rst_n       (rst_n),
            .tune        (due),
            .enable      (1'b1),
            .over        (hot_s || err_over),
            .force_floor (1'b0),
            .flevel      (flevel)
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               panic_q <= 1'b0;
            end else if (due) begin
               panic_q <= hot_s && (flevel == '0);
            end
         end

         assign panic   = panic_q;
         assign vlevel  = VW'(VLEVELS - 1);
         assign oc_en   = 1'b1;
         assign err_clr = due;

         p_thr_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (due && hot_s && flevel != '0) |=> (flevel == $past(flevel) - 1'b1));

         p_thr_panic_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (due && hot_s && flevel == '0) |=> panic);
      end
   endgenerate

endmodule

// File: tb/thermal_oc_governor_tb.sv
module thermal_oc_governor_tb;
   import gov_pkg::*;

   localparam int VL   = 4;
   localparam int FL   = 4;
   localparam int VI   = 3;
   localparam int FI   = 1;
   localparam int FI2  = 2;
   localparam int TLIM = 100;
   localparam int ELIM = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] temp = 8'd50;
   logic [7:0] temp_limit = 8'(TLIM);
   logic [7:0] err_count = 8'd0;
   logic [7:0] err_limit = 8'(ELIM);

   logic [1:0] vlevel, flevel, vlevel2, flevel2;
   logic       panic, oc_en, err_clr, panic2, oc_en2, err_clr2;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   thermal_oc_governor #(
      .VARIANT(GOV_COMBINED), .VLEVELS(VL), .FLEVELS(FL), .TEMP_W(8), .ERR_W(8),
      .V_INTERVAL(VI), .F_INTERVAL(FI)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .temp(temp), .temp_limit(temp_limit),
      .err_count(err_count), .err_limit(err_limit), .vlevel(vlevel),
      .flevel(flevel), .panic(panic), .oc_en(oc_en), .err_clr(err_clr)
   );

   thermal_oc_governor #(
      .VARIANT(GOV_THROTTLE), .VLEVELS(VL), .FLEVELS(FL), .TEMP_W(8), .ERR_W(8),
      .V_INTERVAL(VI), .F_INTERVAL(FI2)
   ) u_thr (
      .clk(clk), .rst_n(rst_n), .temp(temp), .temp_limit(temp_limit),
      .err_count(err_count), .err_limit(err_limit), .vlevel(vlevel2),
      .flevel(flevel2), .panic(panic2), .oc_en(oc_en2), .err_clr(err_clr2)
   );

   // Reference model built from the requirements
   int mt, mf, mv, mfl, mp, moc;
   int nc, nfl, np;
   bit m_td, m_fd, m_hot, m_over, n_d, n_hot;

   assign m_td   = (mt == VI);
   assign m_fd   = (mf == FI);
   assign m_hot  = (int'(temp) >= TLIM);
   assign m_over = (int'(err_count) > ELIM);
   assign n_d    = (nc == FI2);
   assign n_hot  = (int'(temp) > TLIM);

   always @(posedge clk) begin
      if (!rst_n) begin
         mt <= 0; mf <= 0; mv <= VL - 1; mfl <= 0; mp <= 0; moc <= 1;
         nc <= 0; nfl <= 0; np <= 0;
      end else begin
         mt <= m_td ? 0 : mt + 1;
         if (!m_fd) mf <= mf + 1;
         else if (!m_td) mf <= 0;
         if (m_td) begin
            if (m_hot) begin
               if (mv > 0) mv <= mv - 1;
               else begin mp <= 1; moc <= 0; mfl <= 0; end
            end else begin
               if (mv < VL - 1) mv <= mv + 1;
               mp <= 0; moc <= 1;
            end
         end else if (m_fd && moc == 1) begin
            if (m_over) begin if (mfl > 0) mfl <= mfl - 1; end
            else if (mfl < FL - 1) mfl <= mfl + 1;
         end
         nc <= n_d ? 0 : nc + 1;
         if (n_d) begin
            np <= (n_hot && nfl == 0) ? 1 : 0;
            if (n_hot || m_over) begin if (nfl > 0) nfl <= nfl - 1; end
            else if (nfl < FL - 1) nfl <= nfl + 1;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2/R3 vlevel", int'(vlevel), mv);
      chk("R6/R8 flevel", int'(flevel), mfl);
      chk("R4 panic", int'(panic), mp);
      chk("R5 oc_en", int'(oc_en), moc);
      chk("R7 err_clr", int'(err_clr), (m_fd && !m_td) ? 1 : 0);
      chk("R9 throttle flevel", int'(flevel2), nfl);
      chk("R9 throttle panic", int'(panic2), np);
      chk("R9 throttle vlevel", int'(vlevel2), VL - 1);
      chk("R9 throttle oc_en", int'(oc_en2), 1);
      chk("R9 throttle err_clr", int'(err_clr2), n_d ? 1 : 0);
   endtask

   // one cycle: drive at negedge, compare at the following negedge
   task automatic cyc(input int t, input int e);
      temp      = 8'(t);
      err_count = 8'(e);
      @(negedge clk);
      compare_all();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 vlevel", int'(vlevel), VL - 1);
      chk("R1 flevel", int'(flevel), 0);
      chk("R1 panic", int'(panic), 0);
      chk("R1 oc_en", int'(oc_en), 1);
      chk("R1 err_clr", int'(err_clr), 0);
      chk("R1 throttle flevel", int'(flevel2), 0);
      rst_n = 1'b1;

      // R6: cool and error free, frequency climbs and saturates
      for (int i = 0; i < 40; i++) cyc(50, 0);
      chk("R6 saturate top", int'(flevel), FL - 1);
      chk("R3 vlevel max when cool", int'(vlevel), VL - 1);

      // R6: error count equal to limit still counts as a pass
      for (int i = 0; i < 20; i++) cyc(50, ELIM);
      chk("R6 equal limit keeps top", int'(flevel), FL - 1);

      // R6: one above limit drives the frequency to the floor
      for (int i = 0; i < 20; i++) cyc(50, ELIM + 1);
      chk("R6 over limit reaches floor", int'(flevel), 0);

      for (int i = 0; i < 20; i++) cyc(50, 0);

      // R3/R4: temperature exactly at threshold is hot in combined mode
      for (int i = 0; i < 30; i++) cyc(TLIM, 0);
      chk("R3 inclusive threshold walks vlevel to 0", int'(vlevel), 0);
      chk("R4 panic at min voltage", int'(panic), 1);
      chk("R4 flevel forced to floor", int'(flevel), 0);
      chk("R4 oc_en cleared", int'(oc_en), 0);
      chk("R9 strict threshold lets throttle climb", int'(flevel2), FL - 1);

      // R5: cool again, overclock returns only at a thermal evaluation
      for (int i = 0; i < 10; i++) cyc(TLIM - 1, 0);
      chk("R5 oc_en restored", int'(oc_en), 1);
      chk("R3 panic cleared", int'(panic), 0);

      // Sweep of interleaved patterns, compared every cycle
      for (int i = 0; i < 3000; i++) begin
         int t;
         int e;
         t = 92 + ((i / 5) * 7) % 17;
         e = ((i / 3) * 5) % 11;
         if ((i / 200) % 3 == 2) t = 60;
         cyc(t, e);
      end

      finish_run();
   end

endmodule